// File: doc/BRIEF.md
# Zero-Run Monitor for T1/E1 Receive Data

This block sits on the receive side of a T1 or E1 line interface, after line decoding. Every rising edge of the recovered clock delivers one received bit, given as a mark/space indication. The block counts consecutive spaces (zeros). When a run grows longer than the selected line code allows, it raises a one-clock flag.

The allowed run length depends on the line code:
- Plain alternate-mark-inversion on T1 tolerates 15 zeros.
- T1 with zero substitution tolerates 7 zeros.
- E1 with zero substitution tolerates 3 zeros.
- E1 alternate-mark-inversion is never checked.

The flag is not a separate output. It is ORed into the existing bipolar-violation indication and registered, so downstream logic sees a single error strobe. Detection runs only while the decoder is in coder mode and the block's enable bit is set.

Top module: `zero_run_monitor`

## Requirements
- R1: While `rst` is high, and on the first output cycle after it, `bpv_out` is 0 and the zero-run count is 0.
- R2: With `e1_sel`=0 and `ami_sel`=1 (T1 AMI), `bpv_out` goes high for exactly one cycle, after the edge that samples the 16th consecutive zero.
- R3: With `e1_sel`=0 and `ami_sel`=0 (T1 zero substitution), the pulse follows the 8th consecutive zero.
- R4: With `e1_sel`=1 and `ami_sel`=0 (E1 zero substitution), the pulse follows the 4th consecutive zero.
- R5: With `e1_sel`=1 and `ami_sel`=1 (E1 AMI), no zero run ever produces a pulse.
- R6: No zero run produces a pulse unless both `coder_en`=1 and `exz_en`=1.
- R7: `bpv_out` is the OR of `bpv_in` and the zero-run pulse, registered, with one clock of latency.
- R8: A run gives a single pulse however long it lasts. The count saturates at the largest threshold, and the next pulse needs a mark (`rx_mark`=1) first.
- R9: Any mark clears the count, so zeros before a mark never add to zeros after it.
- R10: A change of any of `e1_sel`, `ami_sel`, `coder_en`, `exz_en` clears the count at the edge where the change is first seen. The bit sampled at that edge is not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered receive clock, one bit per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rx_mark | input | 1 | 1 = mark received this bit, 0 = zero |
| e1_sel | input | 1 | 1 = E1 line, 0 = T1 line |
| ami_sel | input | 1 | 1 = AMI code, 0 = zero-substitution code |
| coder_en | input | 1 | Decoder is in coder mode |
| exz_en | input | 1 | Zero-run detection enable bit |
| bpv_in | input | 1 | Bipolar-violation strobe from the decoder |
| bpv_out | output | 1 | Registered violation strobe with zero-run pulses merged in |

## Verification
The hardest case to reach from the ports is a configuration change in the middle of a zero run. The stale count would then meet the new, smaller threshold. The stimulus builds three zeros under T1 AMI, then switches to E1 substitution on a zero bit. With the count carried over, that bit alone would fire. With the count cleared, the pulse must appear only on the fourth zero that follows. Saturation is reached by runs well beyond sixteen zeros, each followed by a check that no second pulse appears.

// File: rtl/zr_pkg.sv
package zr_pkg;

  typedef enum logic [1:0] {
    LC_T1_AMI = 2'd0,
    LC_T1_SUB = 2'd1,
    LC_E1_SUB = 2'd2,
    LC_E1_AMI = 2'd3
  } line_code_e;

  typedef struct packed {
    logic e1;
    logic ami;
    logic coder;
    logic en;
  } zr_cfg_t;

  function automatic line_code_e decode_code(input zr_cfg_t c);
    case ({c.e1, c.ami})
      2'b00:   return LC_T1_SUB;
      2'b01:   return LC_T1_AMI;
      2'b10:   return LC_E1_SUB;
      default: return LC_E1_AMI;
    endcase
  endfunction

endpackage

// File: rtl/zr_mode_ctrl.sv
module zr_mode_ctrl
  import zr_pkg::*;
#(
  parameter int T1_AMI_RUN = 16,
  parameter int T1_SUB_RUN = 8,
  parameter int E1_SUB_RUN = 4,
  parameter int CNT_W      = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  zr_cfg_t          cfg,
  output logic             active,
  output logic             cfg_change,
  output logic [CNT_W-1:0] thr
);

  zr_cfg_t    cfg_q;
  line_code_e code;

  // Last seen configuration; loaded even in reset so the first edge after
  // reset compares against the value the inputs held during reset.
  always_ff @(posedge clk) begin
    cfg_q <= cfg;
  end

  always_comb begin
    code       = decode_code(cfg);
    cfg_change = (cfg != cfg_q);
    active     = cfg.coder && cfg.en && (code != LC_E1_AMI);
    case (code)
      LC_T1_AMI: thr = CNT_W'(T1_AMI_RUN);
      LC_T1_SUB: thr = CNT_W'(T1_SUB_RUN);
      LC_E1_SUB: thr = CNT_W'(E1_SUB_RUN);
      default:   thr = '1;
    endcase
  end

endmodule

// File: rtl/zr_run_counter.sv
module zr_run_counter #(
  parameter int MAX_RUN = 16,
  parameter int CNT_W   = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             clear,
  input  logic [CNT_W-1:0] thr,
  input  logic             rx_mark,
  output logic [CNT_W-1:0] run_cnt,
  output logic             hit
);

  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_RUN);

  logic [CNT_W-1:0] cnt_inc;

  always_comb begin
    cnt_inc = run_cnt + CNT_W'(1);
    // Fires only on the zero that carries the run onto the threshold.
    hit = active && !clear && !rx_mark && (cnt_inc == thr);
  end

  always_ff @(posedge clk) begin
    if (rst || clear || rx_mark || !active) begin
      run_cnt <= '0;
    end else if (run_cnt != CNT_MAX) begin
      run_cnt <= cnt_inc;
    end
  end

endmodule

// File: rtl/zr_merge.sv
module zr_merge (
  input  logic clk,
  input  logic rst,
  input  logic bpv_in,
  input  logic hit,
  output logic bpv_out
);

  always_ff @(posedge clk) begin
    if (rst) begin
      bpv_out <= 1'b0;
    end else begin
      bpv_out <= bpv_in | hit;
    end
  end

endmodule

// File: rtl/zero_run_monitor.sv
module zero_run_monitor
  import zr_pkg::*;
#(
  parameter int T1_AMI_RUN = 16,
  parameter int T1_SUB_RUN = 8,
  parameter int E1_SUB_RUN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_mark,
  input  logic e1_sel,
  input  logic ami_sel,
  input  logic coder_en,
  input  logic exz_en,
  input  logic bpv_in,
  output logic bpv_out
);

  localparam int MAX_A   = (T1_AMI_RUN > T1_SUB_RUN) ? T1_AMI_RUN : T1_SUB_RUN;
  localparam int MAX_RUN = (MAX_A > E1_SUB_RUN) ? MAX_A : E1_SUB_RUN;
  localparam int CNT_W   = $clog2(MAX_RUN + 1);

  zr_cfg_t          cfg;
  logic             active;
  logic             cfg_change;
  logic [CNT_W-1:0] thr;
  logic [CNT_W-1:0] run_cnt;
  logic             exz_hit;

  assign cfg = '{e1: e1_sel, ami: ami_sel, coder: coder_en, en: exz_en};

  zr_mode_ctrl #(
    .T1_AMI_RUN(T1_AMI_RUN),
    .T1_SUB_RUN(T1_SUB_RUN),
    .E1_SUB_RUN(E1_SUB_RUN),
    .CNT_W     (CNT_W)
  ) mode_i (
    .clk       (clk),
    .rst       (rst),
    .cfg       (cfg),
    .active    (active),
    .cfg_change(cfg_change),
    .thr       (thr)
  );

  zr_run_counter #(
    .MAX_RUN(MAX_RUN),
    .CNT_W  (CNT_W)
  ) cnt_i (
    .clk    (clk),
    .rst    (rst),
    .active (active),
    .clear  (cfg_change),
    .thr    (thr),
    .rx_mark(rx_mark),
    .run_cnt(run_cnt),
    .hit    (exz_hit)
  );

  zr_merge merge_i (
    .clk    (clk),
    .rst    (rst),
    .bpv_in (bpv_in),
    .hit    (exz_hit),
    .bpv_out(bpv_out)
  );

endmodule

// File: rtl/zero_run_monitor_chk.sv
module zero_run_monitor_chk #(
  parameter int MAX_RUN = 16,
  parameter int CNT_W   = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             rx_mark,
  input logic             e1_sel,
  input logic             ami_sel,
  input logic             coder_en,
  input logic             exz_en,
  input logic             bpv_in,
  input logic             bpv_out,
  input logic [CNT_W-1:0] run_cnt,
  input logic             exz_hit
);

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (bpv_out == 1'b0) && (run_cnt == '0)); // R1

  AST_INACTIVE_QUIET: assert property (@(posedge clk) disable iff (rst)
    ((!coder_en || !exz_en || (e1_sel && ami_sel)) && !bpv_in) |=> !bpv_out); // R6

  AST_BPV_PASS: assert property (@(posedge clk) disable iff (rst)
    bpv_in |=> bpv_out); // R7

  AST_MARK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    rx_mark |=> (run_cnt == '0)); // R9

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    run_cnt <= CNT_W'(MAX_RUN)); // R8

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    exz_hit |=> !exz_hit); // R8

  AST_CFG_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !$stable({e1_sel, ami_sel, coder_en, exz_en}) |=> (run_cnt == '0)); // R10

endmodule

bind zero_run_monitor zero_run_monitor_chk #(
  .MAX_RUN(MAX_RUN),
  .CNT_W  (CNT_W)
) chk_i (
  .clk     (clk),
  .rst     (rst),
  .rx_mark (rx_mark),
  .e1_sel  (e1_sel),
  .ami_sel (ami_sel),
  .coder_en(coder_en),
  .exz_en  (exz_en),
  .bpv_in  (bpv_in),
  .bpv_out (bpv_out),
  .run_cnt (run_cnt),
  .exz_hit (exz_hit)
);

// File: tb/zero_run_monitor_tb.sv
module zero_run_monitor_tb_top;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_mark = 1'b1;
  logic e1_sel = 1'b0;
  logic ami_sel = 1'b1;
  logic coder_en = 1'b1;
  logic exz_en = 1'b1;
  logic bpv_in = 1'b0;
  logic bpv_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  zero_run_monitor dut_i (
    .clk     (clk),
    .rst     (rst),
    .rx_mark (rx_mark),
    .e1_sel  (e1_sel),
    .ami_sel (ami_sel),
    .coder_en(coder_en),
    .exz_en  (exz_en),
    .bpv_in  (bpv_in),
    .bpv_out (bpv_out)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: bpv_out=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Drive one bit, then sample after the edge that registers it.
  task automatic send(input logic m, input logic b, input logic exp, input string tag);
    rx_mark = m;
    bpv_in  = b;
    @(posedge clk);
    #1;
    check(bpv_out, exp, tag);
  endtask

  // n zeros; pulse expected only on zero number pulse_at (0 = never).
  task automatic run_zeros(input int n, input int pulse_at, input string tag);
    for (int i = 1; i <= n; i++) begin
      send(1'b0, 1'b0, (i == pulse_at), tag);
    end
  endtask

  task automatic set_cfg(input logic e1, input logic ami, input logic cod, input logic en);
    e1_sel = e1; ami_sel = ami; coder_en = cod; exz_en = en;
    send(1'b1, 1'b0, 1'b0, "cfg");
  endtask

  task automatic t_reset();
    rst = 1'b1;
    rx_mark = 1'b0;
    repeat (3) begin
      @(posedge clk);
      #1;
      check(bpv_out, 1'b0, "R1 in reset");
    end
    rst = 1'b0;
    send(1'b0, 1'b0, 1'b0, "R1 after reset");
    send(1'b1, 1'b0, 1'b0, "R1 mark");
  endtask

  task automatic t_t1_ami();
    set_cfg(1'b0, 1'b1, 1'b1, 1'b1);
    run_zeros(40, 16, "R2/R8 T1 AMI long run");
    send(1'b1, 1'b0, 1'b0, "R8 mark");
    run_zeros(16, 16, "R8 second run");
  endtask

  task automatic t_t1_sub();
    set_cfg(1'b0, 1'b0, 1'b1, 1'b1);
    run_zeros(12, 8, "R3 T1 substitution");
  endtask

  task automatic t_e1_sub();
    set_cfg(1'b1, 1'b0, 1'b1, 1'b1);
    run_zeros(3, 0, "R9 short run");
    send(1'b1, 1'b0, 1'b0, "R9 mark");
    run_zeros(6, 4, "R4/R9 E1 substitution");
  endtask

  task automatic t_e1_ami();
    set_cfg(1'b1, 1'b1, 1'b1, 1'b1);
    run_zeros(20, 0, "R5 E1 AMI disabled");
  endtask

  task automatic t_enable();
    set_cfg(1'b0, 1'b1, 1'b1, 1'b0);
    run_zeros(20, 0, "R6 enable off");
    set_cfg(1'b0, 1'b1, 1'b0, 1'b1);
    run_zeros(20, 0, "R6 coder off");
  endtask

  task automatic t_bpv();
    set_cfg(1'b1, 1'b1, 1'b1, 1'b1);
    send(1'b1, 1'b1, 1'b1, "R7 bpv pass");
    send(1'b1, 1'b0, 1'b0, "R7 bpv drop");
    set_cfg(1'b1, 1'b0, 1'b1, 1'b1);
    run_zeros(3, 0, "R7 prefix");
    send(1'b0, 1'b1, 1'b1, "R7 bpv with pulse");
    send(1'b0, 1'b1, 1'b1, "R7 bpv after pulse");
    send(1'b0, 1'b0, 1'b0, "R7 quiet");
  endtask

  task automatic t_cfg_change();
    set_cfg(1'b0, 1'b1, 1'b1, 1'b1);
    run_zeros(3, 0, "R10 prefix");
    e1_sel = 1'b1; ami_sel = 1'b0;
    send(1'b0, 1'b0, 1'b0, "R10 change bit");
    run_zeros(5, 4, "R10 fresh run");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_t1_ami();
    t_t1_sub();
    t_e1_sub();
    t_e1_ami();
    t_enable();
    t_bpv();
    t_cfg_change();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule